// File: doc/BRIEF.md
# Background Scrub and Bad-Block Retirement Controller

This controller keeps a small flash array healthy without host involvement. Once a programmable interval has passed and the system reports that it is idle, the controller starts a pass. The pass walks the physical block indices from low to high. For every block that holds live data and is not marked bad, it sends one read-verify request. It then waits for the verdict of the external error-correction decoder. The verdict is one of three: clean, corrected with a count of flipped bits, or uncorrectable.

Corrected bits are added to a saturating history counter for each block. A small history leads to an in-place refresh request. A history above an elevated-rate threshold leads to a move of the data into a fresh block. A history above the retirement threshold, or any uncorrectable verdict, retires the block: it is marked bad permanently and a spare takes its place. The factory bad-block marks are loaded while reset is held. Marked blocks are never scrubbed and never handed out as spares. The number of spares left is always visible at the ports so that remaining lifetime can be estimated.

Top module: `blk_scrubber`

## Requirements
- R1: While `rst` is high, `factoryBad` is loaded into the bad table. Blocks with an index below NUSE that are not marked start holding live data. Blocks at or above NUSE that are not marked form the spare pool, and `spareLeft` reports their number. Marked blocks are never requested and never chosen as a destination.
- R2: `reqValid` is raised only in a cycle that follows a cycle with `idle` high. A pass starts once at least `interval` cycles have elapsed since the previous pass ended and `idle` is high.
- R3: A pass requests live, unmarked blocks in ascending index order and skips all others. Only one request is outstanding at a time, and the next request waits for `rspValid`.
- R4: A response with `rspStatus`=1 (corrected) adds `rspBits` to the block's saturating history. If the new history is not above `elevThr`, the action is a refresh (`actKind`=1), with `actDst` equal to `actSrc`.
- R5: If the new history is above `elevThr` but not above `retireThr`, the action is a move (`actKind`=2) to the lowest-index free, unmarked block. The source block returns to the free pool, so `spareLeft` is unchanged. If no free block exists, the action is a refresh instead.
- R6: If the new history is above `retireThr`, the action is a retirement (`actKind`=3). The source is marked bad, the lowest-index free block takes over, and `spareLeft` drops by one.
- R7: A response with `rspStatus`=2 or 3 (uncorrectable) sets the sticky `uncorrFlag`. `uncorrBlock` holds the index of the first such block. The block is then retired as in R6.
- R8: When `spareLeft` is 0, `sparesEmpty` is high and no retirement or move takes place. In that state a corrected response yields a refresh and an uncorrectable response yields no action.
- R9: The action is a one-cycle pulse on `actValid`, raised in the cycle after the cycle in which `rspValid` is high. A clean response (`rspStatus`=0) yields no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; loads the factory marks |
| idle | input | 1 | System idle; scrubbing may issue requests |
| interval | input | TW | Minimum cycles between the end of a pass and the start of the next |
| factoryBad | input | NBLK | Factory bad-block marks, sampled during reset |
| elevThr | input | ERRW | Elevated-rate history threshold |
| retireThr | input | ERRW | Retirement history threshold |
| reqValid | output | 1 | Read-verify request pulse |
| reqBlock | output | IW | Block index of the request |
| rspValid | input | 1 | Decoder verdict valid |
| rspStatus | input | 2 | 0 clean, 1 corrected, 2 or 3 uncorrectable |
| rspBits | input | BITW | Number of corrected bits |
| actValid | output | 1 | Maintenance action pulse |
| actKind | output | 2 | 1 refresh, 2 move, 3 retire |
| actSrc | output | IW | Block the action applies to |
| actDst | output | IW | Destination block (equal to the source for a refresh) |
| spareLeft | output | CW | Free, unmarked blocks remaining |
| sparesEmpty | output | 1 | Spare pool exhausted |
| uncorrFlag | output | 1 | Sticky uncorrectable-error flag |
| uncorrBlock | output | IW | First block that reported an uncorrectable verdict |

## Verification
A wrong bad table or live-block table shows up at `reqBlock` in the next pass. It appears either as a skipped block or as a request to a marked block. A wrong free-block choice shows up as a wrong `actDst` on the very next move or retirement. A lost or doubled history update shows up as a wrong `actKind` once the sums cross a threshold a few responses later. A spare-accounting error appears on `spareLeft` in the cycle of the action pulse, and on the action chosen once the pool should have run dry.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_REFRESH = 2'd1,
    ACT_MOVE    = 2'd2,
    ACT_RETIRE  = 2'd3
  } act_e;

  typedef struct packed {
    logic startPass;
    logic issue;
    logic take;
    logic advance;
    logic endPass;
  } strobe_t;
endpackage

// File: rtl/scrub_ctrl.sv
module scrub_ctrl
  import scrub_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    idle,
  input  logic    rspValid,
  input  logic    timerDone,
  input  logic    curEligible,
  input  logic    lastBlk,
  output strobe_t stb
);
  typedef enum logic [1:0] {S_REST, S_SCAN, S_WAIT} state_e;
  state_e state, nxt;

  always_comb begin
    stb = '0;
    nxt = state;
    unique case (state)
      S_REST: begin
        if (timerDone && idle) begin
          stb.startPass = 1'b1;
          nxt = S_SCAN;
        end
      end
      S_SCAN: begin
        if (!curEligible) begin
          if (lastBlk) begin
            stb.endPass = 1'b1;
            nxt = S_REST;
          end else begin
            stb.advance = 1'b1;
          end
        end else if (idle) begin
          stb.issue = 1'b1;
          nxt = S_WAIT;
        end
      end
      S_WAIT: begin
        if (rspValid) begin
          stb.take = 1'b1;
          if (lastBlk) begin
            stb.endPass = 1'b1;
            nxt = S_REST;
          end else begin
            stb.advance = 1'b1;
            nxt = S_SCAN;
          end
        end
      end
      default: nxt = S_REST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_REST;
    else     state <= nxt;
  end
endmodule

// File: rtl/scrub_datapath.sv
module scrub_datapath
  import scrub_pkg::*;
#(
  parameter int NBLK = 8,
  parameter int NUSE = 5,
  parameter int ERRW = 6,
  parameter int BITW = 4,
  parameter int TW   = 16,
  localparam int IW  = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int CW  = $clog2(NBLK + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  strobe_t         stb,
  input  logic [TW-1:0]   interval,
  input  logic [NBLK-1:0] factoryBad,
  input  logic [ERRW-1:0] elevThr,
  input  logic [ERRW-1:0] retireThr,
  input  logic [1:0]      rspStatus,
  input  logic [BITW-1:0] rspBits,
  output logic            timerDone,
  output logic            curEligible,
  output logic            lastBlk,
  output logic            reqValid,
  output logic [IW-1:0]   reqBlock,
  output logic            actValid,
  output act_e            actKind,
  output logic [IW-1:0]   actSrc,
  output logic [IW-1:0]   actDst,
  output logic [CW-1:0]   spareLeft,
  output logic            sparesEmpty,
  output logic            uncorrFlag,
  output logic [IW-1:0]   uncorrBlock
);
  logic [NBLK-1:0] inUse, bad, freeMask;
  logic [ERRW-1:0] errAcc [NBLK];
  logic [IW-1:0]   ptr;
  logic [TW-1:0]   timer;

  logic            freeFound;
  logic [IW-1:0]   freeIdx;
  logic [ERRW:0]   sum;
  logic [ERRW-1:0] newAcc;
  logic            isFixed, isFatal, wantRetire, wantMove;
  act_e            kindNow;

  assign timerDone   = (timer >= interval);
  assign curEligible = inUse[ptr] & ~bad[ptr];
  assign lastBlk     = (32'(ptr) == NBLK - 1);
  assign freeMask    = ~inUse & ~bad;

  // lowest-index free, unmarked block
  always_comb begin
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int i = NBLK - 1; i >= 0; i--) begin
      if (freeMask[i]) begin
        freeFound = 1'b1;
        freeIdx   = IW'(i);
      end
    end
  end

  always_comb begin
    spareLeft = '0;
    for (int i = 0; i < NBLK; i++) spareLeft = spareLeft + CW'(freeMask[i]);
  end
  assign sparesEmpty = ~freeFound;

  // verdict evaluation for the block under the pointer
  assign isFixed = (rspStatus == 2'b01);
  assign isFatal = rspStatus[1];
  assign sum     = {1'b0, errAcc[ptr]} + (ERRW+1)'(rspBits);
  assign newAcc  = sum[ERRW] ? {ERRW{1'b1}} : sum[ERRW-1:0];

  always_comb begin
    wantRetire = isFatal | (isFixed & (newAcc > retireThr));
    wantMove   = isFixed & (newAcc > elevThr) & ~wantRetire;
    if (wantRetire && freeFound)    kindNow = ACT_RETIRE;
    else if (wantMove && freeFound) kindNow = ACT_MOVE;
    else if (isFixed)               kindNow = ACT_REFRESH;
    else                            kindNow = ACT_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bad         <= factoryBad;
      for (int i = 0; i < NBLK; i++) begin
        inUse[i]  <= (i < NUSE) && !factoryBad[i];
        errAcc[i] <= '0;
      end
      ptr         <= '0;
      timer       <= '0;
      reqValid    <= 1'b0;
      reqBlock    <= '0;
      actValid    <= 1'b0;
      actKind     <= ACT_NONE;
      actSrc      <= '0;
      actDst      <= '0;
      uncorrFlag  <= 1'b0;
      uncorrBlock <= '0;
    end else begin
      reqValid <= stb.issue;
      if (stb.issue) reqBlock <= ptr;

      if (stb.endPass)     timer <= '0;
      else if (!timerDone) timer <= timer + 1'b1;

      if (stb.startPass)    ptr <= '0;
      else if (stb.advance) ptr <= ptr + 1'b1;

      actValid <= 1'b0;
      if (stb.take) begin
        actValid <= (kindNow != ACT_NONE);
        actKind  <= kindNow;
        actSrc   <= ptr;
        actDst   <= (kindNow == ACT_MOVE || kindNow == ACT_RETIRE) ? freeIdx : ptr;
        if (isFixed) errAcc[ptr] <= newAcc;
        if (kindNow == ACT_RETIRE) begin
          bad[ptr]       <= 1'b1;
          inUse[ptr]     <= 1'b0;
          inUse[freeIdx] <= 1'b1;
        end else if (kindNow == ACT_MOVE) begin
          inUse[ptr]     <= 1'b0;
          inUse[freeIdx] <= 1'b1;
        end
        if (isFatal && !uncorrFlag) begin
          uncorrFlag  <= 1'b1;
          uncorrBlock <= ptr;
        end
      end
    end
  end
endmodule

// File: rtl/blk_scrubber.sv
module blk_scrubber
  import scrub_pkg::*;
#(
  parameter int NBLK = 8,
  parameter int NUSE = 5,
  parameter int ERRW = 6,
  parameter int BITW = 4,
  parameter int TW   = 16,
  localparam int IW  = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int CW  = $clog2(NBLK + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            idle,
  input  logic [TW-1:0]   interval,
  input  logic [NBLK-1:0] factoryBad,
  input  logic [ERRW-1:0] elevThr,
  input  logic [ERRW-1:0] retireThr,
  output logic            reqValid,
  output logic [IW-1:0]   reqBlock,
  input  logic            rspValid,
  input  logic [1:0]      rspStatus,
  input  logic [BITW-1:0] rspBits,
  output logic            actValid,
  output logic [1:0]      actKind,
  output logic [IW-1:0]   actSrc,
  output logic [IW-1:0]   actDst,
  output logic [CW-1:0]   spareLeft,
  output logic            sparesEmpty,
  output logic            uncorrFlag,
  output logic [IW-1:0]   uncorrBlock
);
  strobe_t stb;
  logic    timerDone, curEligible, lastBlk;
  act_e    kindQ;

  scrub_ctrl ctrl_i (
    .clk(clk), .rst(rst), .idle(idle), .rspValid(rspValid),
    .timerDone(timerDone), .curEligible(curEligible), .lastBlk(lastBlk),
    .stb(stb)
  );

  scrub_datapath #(
    .NBLK(NBLK), .NUSE(NUSE), .ERRW(ERRW), .BITW(BITW), .TW(TW)
  ) dp_i (
    .clk(clk), .rst(rst), .stb(stb), .interval(interval),
    .factoryBad(factoryBad), .elevThr(elevThr), .retireThr(retireThr),
    .rspStatus(rspStatus), .rspBits(rspBits),
    .timerDone(timerDone), .curEligible(curEligible), .lastBlk(lastBlk),
    .reqValid(reqValid), .reqBlock(reqBlock),
    .actValid(actValid), .actKind(kindQ), .actSrc(actSrc), .actDst(actDst),
    .spareLeft(spareLeft), .sparesEmpty(sparesEmpty),
    .uncorrFlag(uncorrFlag), .uncorrBlock(uncorrBlock)
  );

  assign actKind = kindQ;
endmodule

// File: rtl/blk_scrubber_chk.sv
module blk_scrubber_chk #(
  parameter int IW = 3,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          idle,
  input logic          reqValid,
  input logic          rspValid,
  input logic          actValid,
  input logic [1:0]    actKind,
  input logic [CW-1:0] spareLeft,
  input logic          sparesEmpty,
  input logic          uncorrFlag,
  input logic [IW-1:0] uncorrBlock
);
  logic outstanding;

  always_ff @(posedge clk) begin
    if (rst)           outstanding <= 1'b0;
    else if (reqValid) outstanding <= 1'b1;
    else if (rspValid) outstanding <= 1'b0;
  end

  // R2
  req_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    reqValid |-> $past(idle));

  // R3
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    reqValid |-> !outstanding);

  // R9
  act_after_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    actValid |-> $past(rspValid));

  // R6
  spare_no_growth_chk: assert property (@(posedge clk) disable iff (rst)
    spareLeft <= $past(spareLeft));

  // R6
  retire_uses_spare_chk: assert property (@(posedge clk) disable iff (rst)
    (actValid && actKind == 2'd3) |-> (spareLeft == CW'($past(spareLeft) - 1'b1)));

  // R8
  no_retire_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (actValid && actKind == 2'd3) |-> !$past(sparesEmpty));

  // R7
  uncorr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(uncorrFlag) |-> (uncorrFlag && $stable(uncorrBlock)));
endmodule

bind blk_scrubber blk_scrubber_chk #(.IW(IW), .CW(CW)) chk_i (
  .clk(clk), .rst(rst), .idle(idle), .reqValid(reqValid), .rspValid(rspValid),
  .actValid(actValid), .actKind(actKind), .spareLeft(spareLeft),
  .sparesEmpty(sparesEmpty), .uncorrFlag(uncorrFlag), .uncorrBlock(uncorrBlock)
);

// File: tb/blk_scrubber_tb_top.sv
module blk_scrubber_tb_top;
  logic       clk = 1'b0;
  logic       rst, idle, rspValid;
  logic [15:0] interval;
  logic [7:0] factoryBad;
  logic [5:0] elevThr, retireThr;
  logic [1:0] rspStatus;
  logic [3:0] rspBits;
  logic       reqValid, actValid, sparesEmpty, uncorrFlag;
  logic [2:0] reqBlock, actSrc, actDst, uncorrBlock;
  logic [1:0] actKind;
  logic [3:0] spareLeft;

  int nRun = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  blk_scrubber dut_i (
    .clk(clk), .rst(rst), .idle(idle), .interval(interval), .factoryBad(factoryBad),
    .elevThr(elevThr), .retireThr(retireThr), .reqValid(reqValid), .reqBlock(reqBlock),
    .rspValid(rspValid), .rspStatus(rspStatus), .rspBits(rspBits),
    .actValid(actValid), .actKind(actKind), .actSrc(actSrc), .actDst(actDst),
    .spareLeft(spareLeft), .sparesEmpty(sparesEmpty),
    .uncorrFlag(uncorrFlag), .uncorrBlock(uncorrBlock)
  );

  // {blk[3], status[2], bits[4], kind[2], dst[3], spare[4], unc[1], uncBlk[3]}
  // factory marks on blocks 1 and 6, NUSE=5, elevThr=4, retireThr=8
  localparam logic [21:0] VEC [0:10] = '{
    {3'd0, 2'd0, 4'd0, 2'd0, 3'd0, 4'd2, 1'b0, 3'd0},  // clean, no action
    {3'd2, 2'd1, 4'd2, 2'd1, 3'd2, 4'd2, 1'b0, 3'd0},  // R4 refresh
    {3'd3, 2'd1, 4'd5, 2'd2, 3'd5, 4'd2, 1'b0, 3'd0},  // R5 move to 5
    {3'd4, 2'd2, 4'd0, 2'd3, 3'd3, 4'd1, 1'b1, 3'd4},  // R7 retire into 3
    {3'd5, 2'd0, 4'd0, 2'd0, 3'd0, 4'd1, 1'b1, 3'd4},  // moved block visited
    {3'd0, 2'd1, 4'd9, 2'd3, 3'd7, 4'd0, 1'b1, 3'd4},  // R6 retire into 7
    {3'd2, 2'd1, 4'd3, 2'd1, 3'd2, 4'd0, 1'b1, 3'd4},  // R5 fallback refresh
    {3'd3, 2'd3, 4'd0, 2'd0, 3'd0, 4'd0, 1'b1, 3'd4},  // R8 fatal, no action
    {3'd5, 2'd1, 4'd1, 2'd1, 3'd5, 4'd0, 1'b1, 3'd4},  // R4 refresh
    {3'd7, 2'd0, 4'd0, 2'd0, 3'd0, 4'd0, 1'b1, 3'd4},  // spare now live
    {3'd2, 2'd1, 4'd4, 2'd1, 3'd2, 4'd0, 1'b1, 3'd4}   // R8 over retire, refresh
  };

  task automatic check(input string tag, input string what, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic string kindTag(input int k, input int st);
    case (k)
      3: return "R6";
      2: return "R5";
      1: return "R4";
      default: return (st >= 2) ? "R8" : "R9";
    endcase
  endfunction

  task automatic waitReq(output int cnt);
    cnt = 0;
    while (!reqValid && cnt < 5000) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  initial begin
    #(200000 * 10);
    nRun++;
    nFail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int cnt;
    int sawReq;
    rst = 1'b1; idle = 1'b0; interval = 16'd20; factoryBad = 8'b0100_0010;
    elevThr = 6'd4; retireThr = 6'd8; rspValid = 1'b0; rspStatus = 2'd0; rspBits = 4'd0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check("R1", "reset spareLeft", int'(spareLeft), 2);
    check("R8", "reset sparesEmpty", int'(sparesEmpty), 0);
    check("R7", "reset uncorrFlag", int'(uncorrFlag), 0);
    check("R9", "reset actValid", int'(actValid), 0);
    sawReq = 0;
    repeat (40) begin
      @(negedge clk);
      if (reqValid) sawReq = 1;
    end
    check("R2", "request while not idle", sawReq, 0);
    idle = 1'b1;

    for (int v = 0; v < 11; v++) begin
      int eBlk, eSt, eBits, eKind, eDst, eSpare, eUnc, eUncBlk;
      eBlk = int'(VEC[v][21:19]); eSt = int'(VEC[v][18:17]); eBits = int'(VEC[v][16:13]);
      eKind = int'(VEC[v][12:11]); eDst = int'(VEC[v][10:8]); eSpare = int'(VEC[v][7:4]);
      eUnc = int'(VEC[v][3]); eUncBlk = int'(VEC[v][2:0]);
      if (v == 10) begin
        idle = 1'b0;
        sawReq = 0;
        repeat (60) begin
          @(negedge clk);
          if (reqValid) sawReq = 1;
        end
        check("R2", "request with idle low", sawReq, 0);
        idle = 1'b1;
      end
      waitReq(cnt);
      if (v == 5) begin
        check("R2", "interval respected", int'(cnt >= 20 && cnt <= 30), 1);
      end
      check("R3", "request block", int'(reqBlock), eBlk);
      @(negedge clk);
      rspValid = 1'b1; rspStatus = eSt[1:0]; rspBits = eBits[3:0];
      if (v == 1) check("R9", "no early action", int'(actValid), 0);
      @(negedge clk);
      rspValid = 1'b0;
      check(kindTag(eKind, eSt), "actValid", int'(actValid), int'(eKind != 0));
      if (eKind != 0) begin
        check(kindTag(eKind, eSt), "actKind", int'(actKind), eKind);
        check("R9", "actSrc", int'(actSrc), eBlk);
        check(kindTag(eKind, eSt), "actDst", int'(actDst), eDst);
      end
      check("R6", "spareLeft", int'(spareLeft), eSpare);
      check("R8", "sparesEmpty", int'(sparesEmpty), int'(eSpare == 0));
      check("R7", "uncorrFlag", int'(uncorrFlag), eUnc);
      if (eUnc != 0) check("R7", "uncorrBlock", int'(uncorrBlock), eUncBlk);
      if (v == 1) begin
        @(negedge clk);
        check("R9", "action pulse width", int'(actValid), 0);
      end
    end

    // every block factory-marked: nothing to scrub, no spares
    rst = 1'b1; idle = 1'b1; interval = 16'd0; factoryBad = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check("R1", "all marked spareLeft", int'(spareLeft), 0);
    check("R8", "all marked sparesEmpty", int'(sparesEmpty), 1);
    sawReq = 0;
    repeat (40) begin
      @(negedge clk);
      if (reqValid) sawReq = 1;
    end
    check("R1", "marked blocks requested", sawReq, 0);

    // no marks: three spares, first request to block 0
    rst = 1'b1; factoryBad = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check("R1", "unmarked spareLeft", int'(spareLeft), 3);
    waitReq(cnt);
    check("R3", "first block", int'(reqBlock), 0);
    check("R2", "zero interval start", int'(cnt < 10), 1);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule